// File: doc/BRIEF.md
# Paired-Page Translation Lookup

This block translates a virtual address into a physical address by searching a small, fully associative table of translation entries. Each entry covers two adjacent pages, an even one and an odd one, that share a single tag. A per-entry page mask sets the page size. Each half of the pair has its own physical frame, valid bit and dirty (writable) bit. An entry can be private to one 8-bit address-space identifier or shared by all of them through a global bit.

The lookup is purely combinational. The physical address, a write-permission flag and a 3-bit outcome code appear in the same cycle as the virtual address, the current address-space identifier and the read/write flag. The outcome code tells apart four cases:
- a usable translation;
- no entry matched;
- the matched half is not valid;
- a write hit a half that may not be modified.

The surrounding fault logic can therefore raise the right exception. Entries are loaded one at a time through a synchronous write port addressed by index. The search gives precedence to the lowest index.

Top module: `tlbp_lookup`

## Requirements
- R1: After reset every entry holds all-zero fields with both halves invalid and the global bit clear, and no lookup reports MATCH until an entry has been written.
- R2: An entry hits when its global bit is set or its stored identifier equals `lk_asid`, and its tag equals `lk_va` once every bit under the effective mask has been cleared in both values.
- R3: The effective mask is the entry's page mask ORed with bits 12:0. Page-mask bits 12:0 therefore have no effect, and the smallest pair spans 8 KiB.
- R4: The odd half is selected when `lk_va` has a one in the highest bit of the effective mask. `lk_pa` is the selected frame ORed with the bits of `lk_va` under the effective mask shifted right by one.
- R5: When the selected half's valid bit is clear, `lk_res` is 2 (INVALID) for both reads and writes.
- R6: A write (`lk_write`=1) to a valid half whose dirty bit is clear gives `lk_res`=3 (DIRTY). A read of such a half gives `lk_res`=0 (MATCH) with `lk_wperm`=0.
- R7: `lk_wperm` is 1 only when `lk_res` is 0 (MATCH) and the selected half's dirty bit is set. A write to such a half gives MATCH.
- R8: When no entry hits, `lk_res` is 1 (NOMATCH).
- R9: When several entries hit, the one with the lowest index alone determines the outcome and the address.
- R10: When `wr_en` is 1 at a rising clock edge, all fields of entry `wr_idx` are replaced. Lookups see the new contents from that edge on, and no other entry changes.
- R11: Whenever `lk_res` is not MATCH, `lk_pa` is zero and `lk_wperm` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the entry write port |
| rst_n | input | 1 | Active-low asynchronous reset of the entry table |
| wr_en | input | 1 | Load entry `wr_idx` at the next rising edge |
| wr_idx | input | IDX_W | Index of the entry to load |
| wr_tag | input | VA_W | Page-pair tag (bits under the mask are ignored) |
| wr_pmask | input | VA_W | Page-size mask, ones from bit 13 upward for larger pages |
| wr_asid | input | ASID_W | Owning address-space identifier |
| wr_glb | input | 1 | Entry matches every identifier |
| wr_frm0 | input | PA_W | Physical frame of the even half |
| wr_frm1 | input | PA_W | Physical frame of the odd half |
| wr_val0 | input | 1 | Even half valid |
| wr_val1 | input | 1 | Odd half valid |
| wr_dty0 | input | 1 | Even half writable |
| wr_dty1 | input | 1 | Odd half writable |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | 1 for a store access, 0 for a load |
| lk_pa | output | PA_W | Translated physical address, zero unless MATCH |
| lk_wperm | output | 1 | Write permitted for the translated page |
| lk_res | output | 3 | 0 MATCH, 1 NOMATCH, 2 INVALID, 3 DIRTY |

## Verification
The assertions assume that page masks are contiguous runs of ones that begin at bit 13, with no holes, and that frames carry zeros below the half-page size. With such masks the "highest mask bit" selection and the OR-based address merge are well defined. The random stimulus therefore builds each mask as an even-length run of ones starting at bit 13, and clears the frame's low bits to fit the largest mask used. The generated addresses are biased toward stored tags, with a chosen or random identifier, so that hits, global matches, overlaps and misses all occur often.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3
  } tlbp_res_e;

  localparam int PAIR_OFS_BITS = 13;

endpackage

// File: rtl/tlbp_entry_cmp.sv
module tlbp_entry_cmp #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int ASID_W = 8
) (
  input  logic [VA_W-1:0]   e_tag,
  input  logic [VA_W-1:0]   e_pmask,
  input  logic [ASID_W-1:0] e_asid,
  input  logic              e_glb,
  input  logic [PA_W-1:0]   e_frm0,
  input  logic [PA_W-1:0]   e_frm1,
  input  logic              e_val0,
  input  logic              e_val1,
  input  logic              e_dty0,
  input  logic              e_dty1,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  output logic              hit,
  output logic              odd,
  output logic              half_val,
  output logic              half_dty,
  output logic [PA_W-1:0]   pa_raw
);
  import tlbp_pkg::*;

  localparam logic [VA_W-1:0] PAIR_OFS = VA_W'((1 << PAIR_OFS_BITS) - 1);

  function automatic logic [VA_W-1:0] eff_mask(input logic [VA_W-1:0] pm);
    return pm | PAIR_OFS;
  endfunction

  function automatic logic tag_same(input logic [VA_W-1:0] a,
                                    input logic [VA_W-1:0] b,
                                    input logic [VA_W-1:0] m);
    return (a & ~m) == (b & ~m);
  endfunction

  function automatic logic odd_half(input logic [VA_W-1:0] a,
                                    input logic [VA_W-1:0] m);
    return |(a & m & ~(m >> 1));
  endfunction

  function automatic logic [PA_W-1:0] merge_pa(input logic [PA_W-1:0] frm,
                                               input logic [VA_W-1:0] a,
                                               input logic [VA_W-1:0] m);
    return frm | PA_W'(a & (m >> 1));
  endfunction

  logic [VA_W-1:0] m;
  logic            id_ok;

  always_comb begin
    m        = eff_mask(e_pmask);
    id_ok    = e_glb || (e_asid == asid);
    hit      = id_ok && tag_same(va, e_tag, m);
    odd      = odd_half(va, m);
    half_val = odd ? e_val1 : e_val0;
    half_dty = odd ? e_dty1 : e_dty0;
    pa_raw   = merge_pa(odd ? e_frm1 : e_frm0, va, m);
  end

endmodule

// File: rtl/tlbp_first_hit.sv
module tlbp_first_hit #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hit_vec,
  output logic [N-1:0]     sel_vec,
  output logic [IDX_W-1:0] sel_idx,
  output logic             any_hit
);

  always_comb begin
    sel_vec = '0;
    sel_idx = '0;
    any_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i] && !any_hit) begin
        any_hit    = 1'b1;
        sel_vec[i] = 1'b1;
        sel_idx    = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/tlbp_outcome.sv
module tlbp_outcome #(
  parameter int PA_W = 32
) (
  input  logic            any_hit,
  input  logic            half_val,
  input  logic            half_dty,
  input  logic            is_write,
  input  logic [PA_W-1:0] pa_raw,
  output logic [2:0]      res,
  output logic [PA_W-1:0] pa,
  output logic            wperm
);
  import tlbp_pkg::*;

  tlbp_res_e r;

  always_comb begin
    if (!any_hit)                  r = RES_NOMATCH;
    else if (!half_val)            r = RES_INVALID;
    else if (is_write && !half_dty) r = RES_DIRTY;
    else                           r = RES_MATCH;
    res   = r;
    pa    = (r == RES_MATCH) ? pa_raw : '0;
    wperm = (r == RES_MATCH) && half_dty;
  end

endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup #(
  parameter int ENTRIES = 8,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_tag,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_glb,
  input  logic [PA_W-1:0]   wr_frm0,
  input  logic [PA_W-1:0]   wr_frm1,
  input  logic              wr_val0,
  input  logic              wr_val1,
  input  logic              wr_dty0,
  input  logic              wr_dty1,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_write,
  output logic [PA_W-1:0]   lk_pa,
  output logic              lk_wperm,
  output logic [2:0]        lk_res
);

  logic [VA_W-1:0]   e_tag   [ENTRIES];
  logic [VA_W-1:0]   e_pmask [ENTRIES];
  logic [ASID_W-1:0] e_asid  [ENTRIES];
  logic [PA_W-1:0]   e_frm0  [ENTRIES];
  logic [PA_W-1:0]   e_frm1  [ENTRIES];
  logic [ENTRIES-1:0] e_glb, e_val0, e_val1, e_dty0, e_dty1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        e_tag[i]   <= '0;
        e_pmask[i] <= '0;
        e_asid[i]  <= '0;
        e_frm0[i]  <= '0;
        e_frm1[i]  <= '0;
      end
      e_glb  <= '0;
      e_val0 <= '0;
      e_val1 <= '0;
      e_dty0 <= '0;
      e_dty1 <= '0;
    end else if (wr_en) begin
      e_tag[wr_idx]   <= wr_tag;
      e_pmask[wr_idx] <= wr_pmask;
      e_asid[wr_idx]  <= wr_asid;
      e_frm0[wr_idx]  <= wr_frm0;
      e_frm1[wr_idx]  <= wr_frm1;
      e_glb[wr_idx]   <= wr_glb;
      e_val0[wr_idx]  <= wr_val0;
      e_val1[wr_idx]  <= wr_val1;
      e_dty0[wr_idx]  <= wr_dty0;
      e_dty1[wr_idx]  <= wr_dty1;
    end
  end

  logic [ENTRIES-1:0] hit_vec, odd_vec, hv_vec, hd_vec;
  logic [PA_W-1:0]    pa_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlbp_entry_cmp #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) u_cmp (
      .e_tag    (e_tag[g]),
      .e_pmask  (e_pmask[g]),
      .e_asid   (e_asid[g]),
      .e_glb    (e_glb[g]),
      .e_frm0   (e_frm0[g]),
      .e_frm1   (e_frm1[g]),
      .e_val0   (e_val0[g]),
      .e_val1   (e_val1[g]),
      .e_dty0   (e_dty0[g]),
      .e_dty1   (e_dty1[g]),
      .va       (lk_va),
      .asid     (lk_asid),
      .hit      (hit_vec[g]),
      .odd      (odd_vec[g]),
      .half_val (hv_vec[g]),
      .half_dty (hd_vec[g]),
      .pa_raw   (pa_arr[g])
    );
  end

  logic [ENTRIES-1:0] sel_vec;
  logic [IDX_W-1:0]   sel_idx;
  logic               any_hit;

  tlbp_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
    .hit_vec (hit_vec),
    .sel_vec (sel_vec),
    .sel_idx (sel_idx),
    .any_hit (any_hit)
  );

  logic            sel_v, sel_d, sel_odd;
  logic [PA_W-1:0] sel_pa;

  always_comb begin
    sel_v   = hv_vec[sel_idx];
    sel_d   = hd_vec[sel_idx];
    sel_odd = odd_vec[sel_idx];
    sel_pa  = pa_arr[sel_idx];
  end

  tlbp_outcome #(.PA_W(PA_W)) u_out (
    .any_hit  (any_hit),
    .half_val (sel_v),
    .half_dty (sel_d),
    .is_write (lk_write),
    .pa_raw   (sel_pa),
    .res      (lk_res),
    .pa       (lk_pa),
    .wperm    (lk_wperm)
  );

endmodule

// File: rtl/tlbp_lookup_chk.sv
module tlbp_lookup_chk #(
  parameter int ENTRIES = 8,
  parameter int PA_W    = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               lk_write,
  input logic [2:0]         lk_res,
  input logic [PA_W-1:0]    lk_pa,
  input logic               lk_wperm,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] sel_vec,
  input logic               any_hit,
  input logic               sel_v,
  input logic               sel_d
);
  import tlbp_pkg::*;

  logic seen_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_wr <= 1'b0;
    else if (wr_en) seen_wr <= 1'b1;
  end

  AST_RESET_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_wr |-> lk_res != RES_MATCH); // R1

  AST_MISS_IS_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !any_hit |-> lk_res == RES_NOMATCH); // R8

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ($countones(sel_vec) == 1 && (sel_vec & ~hit_vec) == '0)); // R9

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (hit_vec & (sel_vec - 1'b1)) == '0); // R9

  AST_INVALID_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (any_hit && !sel_v) |-> lk_res == RES_INVALID); // R5

  AST_DIRTY_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_res == RES_DIRTY |-> (lk_write && !sel_d && sel_v)); // R6

  AST_WPERM_NEEDS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_wperm |-> (lk_res == RES_MATCH && sel_d)); // R7

  AST_MISS_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_res != RES_MATCH |-> (lk_pa == '0 && !lk_wperm)); // R11

endmodule

bind tlbp_lookup tlbp_lookup_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .lk_write (lk_write),
  .lk_res   (lk_res),
  .lk_pa    (lk_pa),
  .lk_wperm (lk_wperm),
  .hit_vec  (hit_vec),
  .sel_vec  (sel_vec),
  .any_hit  (any_hit),
  .sel_v    (sel_v),
  .sel_d    (sel_d)
);

// File: tb/tb_tlbp_lookup.sv
module tb_tlbp_lookup;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_tag = '0, wr_pmask = '0, wr_frm0 = '0, wr_frm1 = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_glb = 0, wr_val0 = 0, wr_val1 = 0, wr_dty0 = 0, wr_dty1 = 0;
  logic [31:0] lk_va = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_write = 1'b0;
  logic [31:0] lk_pa;
  logic        lk_wperm;
  logic [2:0]  lk_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlbp_lookup dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_pmask(wr_pmask), .wr_asid(wr_asid), .wr_glb(wr_glb), .wr_frm0(wr_frm0),
    .wr_frm1(wr_frm1), .wr_val0(wr_val0), .wr_val1(wr_val1), .wr_dty0(wr_dty0),
    .wr_dty1(wr_dty1), .lk_va(lk_va), .lk_asid(lk_asid), .lk_write(lk_write),
    .lk_pa(lk_pa), .lk_wperm(lk_wperm), .lk_res(lk_res)
  );

  // reference table
  logic [31:0] m_tag [N], m_pm [N], m_f0 [N], m_f1 [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_v0 [N], m_v1 [N], m_d0 [N], m_d1 [N];

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_tag[i] = 0; m_pm[i] = 0; m_f0[i] = 0; m_f1[i] = 0; m_asid[i] = 0;
      m_g[i] = 0; m_v0[i] = 0; m_v1[i] = 0; m_d0[i] = 0; m_d1[i] = 0;
    end
  endtask

  // expected outcome: half size taken as (mask+1)/2 for a contiguous low mask
  task automatic predict(input logic [31:0] va, input logic [7:0] asid, input logic wr,
                         output logic [2:0] r, output logic [31:0] pa, output logic wp);
    r = 3'd1; pa = 0; wp = 0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] span, half;
      logic odd, v, d;
      span = m_pm[i] | 32'h0000_1FFF;
      half = (span + 32'd1) >> 1;
      if ((m_g[i] || m_asid[i] == asid) && (va / (span + 32'd1)) == (m_tag[i] / (span + 32'd1))) begin
        odd = (va & half) != 0;
        v = odd ? m_v1[i] : m_v0[i];
        d = odd ? m_d1[i] : m_d0[i];
        if (!v) r = 3'd2;
        else if (wr && !d) r = 3'd3;
        else begin
          r = 3'd0;
          pa = (odd ? m_f1[i] : m_f0[i]) | (va % half);
          wp = d;
        end
        return;
      end
    end
  endtask

  task automatic load(input int idx, input logic [31:0] tag, input logic [31:0] pm,
                      input logic [7:0] asid, input logic g, input logic [31:0] f0,
                      input logic [31:0] f1, input logic v0, input logic v1,
                      input logic d0, input logic d1);
    @(negedge clk);
    wr_en = 1; wr_idx = 3'(idx); wr_tag = tag; wr_pmask = pm; wr_asid = asid; wr_glb = g;
    wr_frm0 = f0; wr_frm1 = f1; wr_val0 = v0; wr_val1 = v1; wr_dty0 = d0; wr_dty1 = d1;
    @(posedge clk);
    m_tag[idx] = tag; m_pm[idx] = pm; m_asid[idx] = asid; m_g[idx] = g; m_f0[idx] = f0;
    m_f1[idx] = f1; m_v0[idx] = v0; m_v1[idx] = v1; m_d0[idx] = d0; m_d1[idx] = d1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string tag, input logic [31:0] va, input logic [7:0] asid,
                      input logic wr);
    logic [2:0] er; logic [31:0] ep; logic ew;
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_write = wr;
    #1;
    predict(va, asid, wr, er, ep, ew);
    checks++;
    if (lk_res !== er || lk_pa !== ep || lk_wperm !== ew) begin
      fails++;
      $display("FAIL %s va=%h res=%0d exp=%0d pa=%h exp=%h wperm=%0d exp=%0d",
               tag, va, lk_res, er, lk_pa, ep, lk_wperm, ew);
    end
  endtask

  task automatic expect_res(input string tag, input logic [2:0] exp);
    checks++;
    if (lk_res !== exp) begin
      fails++;
      $display("FAIL %s res=%0d exp=%0d", tag, lk_res, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired res=%0d exp=finished", lk_res);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset table never matches
    look("R1", 32'h0000_0000, 8'h00, 0); expect_res("R1", 3'd2);
    look("R1", 32'h8000_1234, 8'h3C, 1); expect_res("R1", 3'd1);

    // R10: write becomes visible only after the edge
    @(negedge clk);
    wr_en = 1; wr_idx = 0; wr_tag = 32'h0040_0000; wr_pmask = 0; wr_asid = 8'h05; wr_glb = 0;
    wr_frm0 = 32'h1000_0000; wr_frm1 = 32'h2000_0000; wr_val0 = 1; wr_val1 = 1;
    wr_dty0 = 1; wr_dty1 = 0;
    lk_va = 32'h0040_0123; lk_asid = 8'h05; lk_write = 0;
    #1; expect_res("R10 before edge", 3'd1);
    @(posedge clk);
    m_tag[0] = 32'h0040_0000; m_pm[0] = 0; m_asid[0] = 8'h05; m_g[0] = 0;
    m_f0[0] = 32'h1000_0000; m_f1[0] = 32'h2000_0000; m_v0[0] = 1; m_v1[0] = 1;
    m_d0[0] = 1; m_d1[0] = 0;
    @(negedge clk); wr_en = 0;
    look("R10", 32'h0040_0123, 8'h05, 0); expect_res("R10 after edge", 3'd0);

    // R4 / R7: even half, dirty set
    look("R4", 32'h0040_0ABC, 8'h05, 1);
    // R4 / R6: odd half, clean
    look("R4", 32'h0040_1ABC, 8'h05, 0);
    look("R6", 32'h0040_1ABC, 8'h05, 1); expect_res("R6", 3'd3);
    // R2 / R8: wrong identifier, then global entry
    look("R2", 32'h0040_0123, 8'h06, 0); expect_res("R8", 3'd1);
    load(1, 32'h0060_0000, 0, 8'h77, 1, 32'h3000_0000, 32'h3100_0000, 1, 1, 1, 1);
    look("R2", 32'h0060_1004, 8'hAA, 1); expect_res("R7", 3'd0);
    // R5: invalid half for read and write
    load(2, 32'h0070_0000, 0, 8'h05, 0, 32'h4000_0000, 32'h4100_0000, 0, 1, 1, 1);
    look("R5", 32'h0070_0010, 8'h05, 0); expect_res("R5", 3'd2);
    look("R5", 32'h0070_0010, 8'h05, 1); expect_res("R5", 3'd2);
    // R3: low page-mask bits ignored; 16K pages use bit 14
    load(3, 32'h0080_0000, 32'h0000_1FFF, 8'h05, 0, 32'h5000_0000, 32'h5100_0000, 1, 1, 0, 1);
    look("R3", 32'h0080_1FF0, 8'h05, 0);
    load(4, 32'h0100_0000, 32'h0000_6000, 8'h05, 0, 32'h6000_0000, 32'h6100_0000, 1, 1, 1, 1);
    look("R3", 32'h0100_4123, 8'h05, 0);
    look("R3", 32'h0100_3FFF, 8'h05, 0);
    // R9: overlapping entries, lowest index wins
    load(6, 32'h0200_0000, 0, 8'h05, 0, 32'h7000_0000, 32'h7100_0000, 1, 1, 1, 1);
    load(5, 32'h0200_0000, 0, 8'h05, 0, 32'h7700_0000, 32'h7800_0000, 1, 1, 0, 0);
    look("R9", 32'h0200_0044, 8'h05, 0);
    look("R9", 32'h0200_0044, 8'h05, 1); expect_res("R9", 3'd3);
    // R11: outputs cleared on a miss
    look("R11", 32'hF000_0000, 8'h05, 1);

    // random mix
    for (int it = 0; it < 4000; it++) begin
      if ($urandom_range(3) == 0) begin
        int k; logic [31:0] pm, tg, f0, f1;
        k = $urandom_range(5);
        pm = ((32'd1 << (2 * k)) - 1) << 13;
        tg = $urandom();
        f0 = $urandom() & 32'hFF80_0000;
        f1 = $urandom() & 32'hFF80_0000;
        load($urandom_range(N - 1), tg, pm, 8'($urandom_range(3)), ($urandom_range(4) == 0),
             f0, f1, 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      end else begin
        int i; logic [31:0] span, va; logic [7:0] as;
        i = $urandom_range(N - 1);
        span = m_pm[i] | 32'h1FFF;
        va = ($urandom_range(4) == 0) ? $urandom() : ((m_tag[i] & ~span) | ($urandom() & span));
        as = ($urandom_range(3) == 0) ? 8'($urandom_range(3)) : m_asid[i];
        look("R2 R4 R6 R7 R9 random", va, as, 1'($urandom()));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule